// File: doc/BRIEF.md
# Operate Micro-Instruction Execution Unit

This unit carries out the register-only "operate" instructions of a 12-bit single-accumulator processor. A single instruction word can pack several small operations on the accumulator (AC) and the one-bit link (L). The unit performs them in a fixed order and returns the new AC and L values. It also returns a skip request, which tells the sequencer to step over the next instruction, and a halt request.

Two groups share the operate opcode, and bit 8 selects between them. The first group clears, complements and increments the 13-bit link:accumulator pair, then rotates it. The second group tests the incoming AC and L and produces a skip. The skip test takes either an OR form or an AND form. After the test, the group can clear AC, OR in the front-panel switch word and raise halt. The third encoding, and any word whose opcode is not the operate opcode, passes AC and L through unchanged.

The datapath is combinational and ends in one register stage. A word presented with `in_valid` produces its result one cycle later, with `out_valid` high.

Top module: `opr_micro_unit`

## Requirements
- R1: Results appear on the outputs on the clock edge that follows the edge at which `in_valid` is sampled high, and `out_valid` is high for exactly those cycles. While reset is active, every output is 0. In a cycle where `out_valid` is low, `skip_out` and `halt_out` are 0.
- R2: A word with bits 11:9 = 111 and bit 8 = 0 is a first-group word. In such a word, bit 7 clears AC and bit 6 clears L. These clears come before every other step, so 7200 clears AC, 7100 clears L and 7300 clears both.
- R3: In a first-group word, bit 5 inverts AC and bit 4 inverts L. Both act after the clears, so 7240 leaves AC = 7777.
- R4: In a first-group word, bit 0 adds one to L:AC as a 13-bit number, with the carry out of AC landing in L. The add comes after the complements and before the rotate.
- R5: The first-group rotate field is bits 3:1 and acts on the 13-bit L:AC ring as the last step. The codes are: 100 rotates right one place, 010 rotates left one place, 101 rotates right two places, and 011 rotates left two places.
- R6: Rotate code 001 exchanges the upper and lower 6-bit halves of AC and leaves L alone. Codes 110 and 111 perform no rotation.
- R7: A word with bits 11:8 = 1111 and bit 0 = 0 is a second-group word. With bit 3 (sense) clear, the skip is the OR of the selected tests. Bit 6 tests AC negative (AC bit 11 set), bit 5 tests AC zero, and bit 4 tests L set.
- R8: In a second-group word with sense set, the skip is the AND of the selected tests. Bit 6 then tests AC non-negative, bit 5 tests AC non-zero, and bit 4 tests L clear. Sense alone (7410) always skips.
- R9: A second-group word computes its skip from the incoming AC and L. It then clears AC if bit 7 is set, and after that ORs in the switch word if bit 2 is set. L is never changed.
- R10: Bit 2 of the instruction word has no effect on `halt_out`. Bit 1 of a second-group word raises `halt_out`, and `halt_out` stays 0 for every other word.
- R11: The following words leave AC and L unchanged and give skip = 0 and halt = 0: a first-group word with no operation bits set (7000), a second-group word with no operation bits set (7400), any word with bits 11:8 = 1111 and bit 0 = 1, and any word whose bits 11:9 are not 111.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction and operands are present this cycle |
| instr | input | 12 | Instruction word |
| acc_in | input | DATA_W | Current accumulator |
| link_in | input | 1 | Current link bit |
| switches | input | DATA_W | Front-panel switch word |
| out_valid | output | 1 | Results valid |
| acc_out | output | DATA_W | New accumulator |
| link_out | output | 1 | New link bit |
| skip_out | output | 1 | Skip the next instruction |
| halt_out | output | 1 | Halt request |

## Verification
The bench checks the ordering corners. If clear and complement ran in the wrong order, 7240 would not give 7777. If the increment came after the rotate, the IAC-plus-rotate case would miss the carry into L. If the skip were taken after the clear, a negative AC combined with clear would fail to skip.

The bench also checks that the rotate codes move bits through L and not around AC alone. The two-place rotations, the half swap and the 110/111 codes each have a directed case.

The AND form of the skip is checked against the OR form on the same operands, because a swapped sense bit inverts every result. The third-group encoding and foreign opcodes are checked to confirm that they leave AC, L, skip and halt untouched.

// File: rtl/opr_pkg.sv
package opr_pkg;

   localparam int INSTR_W = 12;

   typedef enum logic [2:0] {
      ROT_NONE  = 3'b000,
      ROT_SWAP  = 3'b001,
      ROT_LEFT1 = 3'b010,
      ROT_LEFT2 = 3'b011,
      ROT_RGHT1 = 3'b100,
      ROT_RGHT2 = 3'b101,
      ROT_BAD0  = 3'b110,
      ROT_BAD1  = 3'b111
   } rot_code_e;

   typedef struct packed {
      logic      clr_ac;
      logic      clr_lk;
      logic      inv_ac;
      logic      inv_lk;
      logic      inc;
      rot_code_e rot;
   } alu_ctl_t;

   typedef struct packed {
      logic clr_ac;
      logic tst_neg;
      logic tst_zero;
      logic tst_link;
      logic sense;
      logic or_sw;
      logic halt;
   } tst_ctl_t;

   function automatic logic is_alu_word(input logic [INSTR_W-1:0] w);
      return (w[11:9] == 3'b111) && !w[8];
   endfunction

   function automatic logic is_tst_word(input logic [INSTR_W-1:0] w);
      return (w[11:8] == 4'hF) && !w[0];
   endfunction

   function automatic alu_ctl_t dec_alu(input logic [INSTR_W-1:0] w);
      alu_ctl_t c;
      c.clr_ac = w[7];
      c.clr_lk = w[6];
      c.inv_ac = w[5];
      c.inv_lk = w[4];
      c.inc    = w[0];
      c.rot    = rot_code_e'(w[3:1]);
      return c;
   endfunction

   function automatic tst_ctl_t dec_tst(input logic [INSTR_W-1:0] w);
      tst_ctl_t c;
      c.clr_ac   = w[7];
      c.tst_neg  = w[6];
      c.tst_zero = w[5];
      c.tst_link = w[4];
      c.sense    = w[3];
      c.or_sw    = w[2];
      c.halt     = w[1];
      return c;
   endfunction

endpackage

// File: rtl/opr_rotate.sv
module opr_rotate
   import opr_pkg::*;
#(
   parameter int DATA_W  = 12,
   parameter bit SWAP_EN = 1'b1
)(
   input  logic [DATA_W:0] ring_in,
   input  rot_code_e       code,
   output logic [DATA_W:0] ring_out
);
   localparam int RING_W = DATA_W + 1;
   localparam int HALF_W = DATA_W / 2;

   logic [DATA_W:0] swapped;

   generate
      if (SWAP_EN) begin : g_swap
         assign swapped = {ring_in[DATA_W], ring_in[HALF_W-1:0], ring_in[DATA_W-1:HALF_W]};
      end else begin : g_noswap
         assign swapped = ring_in;
      end
   endgenerate

   always_comb begin
      unique case (code)
         ROT_RGHT1: ring_out = {ring_in[0], ring_in[RING_W-1:1]};
         ROT_RGHT2: ring_out = {ring_in[1:0], ring_in[RING_W-1:2]};
         ROT_LEFT1: ring_out = {ring_in[RING_W-2:0], ring_in[RING_W-1]};
         ROT_LEFT2: ring_out = {ring_in[RING_W-3:0], ring_in[RING_W-1:RING_W-2]};
         ROT_SWAP:  ring_out = swapped;
         default:   ring_out = ring_in;
      endcase
   end

   // R5: any rotate or swap only moves bits, never creates or drops one
   always_comb begin
      a_r5_ones_kept: assert ($countones(ring_out) == $countones(ring_in));
   end

endmodule

// File: rtl/opr_alu_grp.sv
module opr_alu_grp
   import opr_pkg::*;
#(
   parameter int DATA_W  = 12,
   parameter bit SWAP_EN = 1'b1
)(
   input  alu_ctl_t          ctl,
   input  logic [DATA_W-1:0] ac_in,
   input  logic              lk_in,
   output logic [DATA_W-1:0] ac_out,
   output logic              lk_out
);
   logic [DATA_W-1:0] ac_clr, ac_inv;
   logic              lk_clr, lk_inv;
   logic [DATA_W:0]   ring_inc, ring_rot;

   always_comb begin
      ac_clr   = ctl.clr_ac ? '0 : ac_in;
      lk_clr   = ctl.clr_lk ? 1'b0 : lk_in;
      ac_inv   = ctl.inv_ac ? ~ac_clr : ac_clr;
      lk_inv   = ctl.inv_lk ? ~lk_clr : lk_clr;
      ring_inc = {lk_inv, ac_inv} + {{DATA_W{1'b0}}, ctl.inc};
   end

   opr_rotate #(.DATA_W(DATA_W), .SWAP_EN(SWAP_EN)) u_rot (
      .ring_in  (ring_inc),
      .code     (ctl.rot),
      .ring_out (ring_rot)
   );

   assign {lk_out, ac_out} = ring_rot;

   // R6: the half swap never alters the link
   always_comb begin
      if (ctl.rot == ROT_SWAP)
         a_r6_swap_keeps_link: assert (lk_out == ring_inc[DATA_W]);
   end

endmodule

// File: rtl/opr_tst_grp.sv
module opr_tst_grp
   import opr_pkg::*;
#(
   parameter int DATA_W = 12
)(
   input  tst_ctl_t          ctl,
   input  logic [DATA_W-1:0] ac_in,
   input  logic              lk_in,
   input  logic [DATA_W-1:0] sw_in,
   output logic [DATA_W-1:0] ac_out,
   output logic              skip,
   output logic              halt
);
   logic any_hit;
   logic [DATA_W-1:0] ac_clr;

   always_comb begin
      any_hit = (ctl.tst_neg  & ac_in[DATA_W-1])
              | (ctl.tst_zero & (ac_in == '0))
              | (ctl.tst_link & lk_in);
      skip    = ctl.sense ? ~any_hit : any_hit;
      ac_clr  = ctl.clr_ac ? '0 : ac_in;
      ac_out  = ctl.or_sw ? (ac_clr | sw_in) : ac_clr;
      halt    = ctl.halt;
   end

   // R8: sense with no selected test is an unconditional skip
   always_comb begin
      if (ctl.sense && !ctl.tst_neg && !ctl.tst_zero && !ctl.tst_link)
         a_r8_plain_skip: assert (skip);
   end

endmodule

// File: rtl/opr_micro_unit.sv
module opr_micro_unit
   import opr_pkg::*;
#(
   parameter int DATA_W  = 12,
   parameter bit SWAP_EN = 1'b1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [11:0]       instr,
   input  logic [DATA_W-1:0] acc_in,
   input  logic              link_in,
   input  logic [DATA_W-1:0] switches,
   output logic              out_valid,
   output logic [DATA_W-1:0] acc_out,
   output logic              link_out,
   output logic              skip_out,
   output logic              halt_out
);
   generate
      if (DATA_W < 4 || (DATA_W % 2) != 0) begin : g_bad_width
         $error("opr_micro_unit: DATA_W must be even and at least 4");
      end
   endgenerate

   logic              sel_alu, sel_tst;
   alu_ctl_t          alu_ctl;
   tst_ctl_t          tst_ctl;
   logic [DATA_W-1:0] alu_ac, tst_ac, nxt_ac;
   logic              alu_lk, tst_skip, tst_halt, nxt_lk, nxt_skip, nxt_halt;

   assign sel_alu = is_alu_word(instr);
   assign sel_tst = is_tst_word(instr);
   assign alu_ctl = dec_alu(instr);
   assign tst_ctl = dec_tst(instr);

   opr_alu_grp #(.DATA_W(DATA_W), .SWAP_EN(SWAP_EN)) u_alu (
      .ctl    (alu_ctl),
      .ac_in  (acc_in),
      .lk_in  (link_in),
      .ac_out (alu_ac),
      .lk_out (alu_lk)
   );

   opr_tst_grp #(.DATA_W(DATA_W)) u_tst (
      .ctl    (tst_ctl),
      .ac_in  (acc_in),
      .lk_in  (link_in),
      .sw_in  (switches),
      .ac_out (tst_ac),
      .skip   (tst_skip),
      .halt   (tst_halt)
   );

   always_comb begin
      nxt_ac   = acc_in;
      nxt_lk   = link_in;
      nxt_skip = 1'b0;
      nxt_halt = 1'b0;
      if (sel_alu) begin
         nxt_ac = alu_ac;
         nxt_lk = alu_lk;
      end else if (sel_tst) begin
         nxt_ac   = tst_ac;
         nxt_skip = tst_skip;
         nxt_halt = tst_halt;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         acc_out   <= '0;
         link_out  <= 1'b0;
         skip_out  <= 1'b0;
         halt_out  <= 1'b0;
      end else begin
         out_valid <= in_valid;
         skip_out  <= in_valid & nxt_skip;
         halt_out  <= in_valid & nxt_halt;
         if (in_valid) begin
            acc_out  <= nxt_ac;
            link_out <= nxt_lk;
         end
      end
   end

   a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   a_r1_valid_drops: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid && !skip_out && !halt_out);
   a_r10_halt_source: assert property (@(posedge clk) disable iff (!rst_n)
      halt_out |-> $past(in_valid && instr[11:8] == 4'hF && !instr[0] && instr[1]));
   a_r7_skip_source: assert property (@(posedge clk) disable iff (!rst_n)
      skip_out |-> $past(in_valid && instr[11:8] == 4'hF && !instr[0]));
   a_r9_link_kept: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && instr[11:8] == 4'hF |=> link_out == $past(link_in));
   a_r9_clear_only: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && instr[11:8] == 4'hF && !instr[0] && instr[7] && !instr[2] |=> acc_out == '0);
   a_r11_foreign_pass: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && instr[11:9] != 3'b111 |=>
         acc_out == $past(acc_in) && link_out == $past(link_in) && !skip_out && !halt_out);

endmodule

// File: tb/sim_opr_micro_unit.sv
`timescale 1ns/1ps
module sim_opr_micro_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [11:0] instr = '0;
   logic [11:0] acc_in = '0;
   logic        link_in = 1'b0;
   logic [11:0] switches = '0;
   logic        out_valid;
   logic [11:0] acc_out;
   logic        link_out, skip_out, halt_out;

   int total = 0;
   int bad   = 0;

   always #2.5 clk = ~clk;

   opr_micro_unit u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
      .acc_in(acc_in), .link_in(link_in), .switches(switches),
      .out_valid(out_valid), .acc_out(acc_out), .link_out(link_out),
      .skip_out(skip_out), .halt_out(halt_out)
   );

   task automatic exec(input logic [11:0] w, input logic [11:0] a,
                       input logic l, input logic [11:0] s);
      instr = w; acc_in = a; link_in = l; switches = s; in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic chk(input string req, input logic [11:0] ea, input logic el,
                      input logic es, input logic eh);
      total++;
      if (out_valid !== 1'b1 || acc_out !== ea || link_out !== el ||
          skip_out !== es || halt_out !== eh) begin
         bad++;
         $display("FAIL %s instr=%o: got v=%b ac=%o l=%b skip=%b halt=%b, expected v=1 ac=%o l=%b skip=%b halt=%b",
                  req, instr, out_valid, acc_out, link_out, skip_out, halt_out, ea, el, es, eh);
      end
   endtask

   task automatic t_reset();
      total++;
      if (out_valid !== 1'b0 || acc_out !== 12'o0 || link_out !== 1'b0 ||
          skip_out !== 1'b0 || halt_out !== 1'b0) begin
         bad++;
         $display("FAIL R1 reset: got v=%b ac=%o l=%b s=%b h=%b, expected all 0",
                  out_valid, acc_out, link_out, skip_out, halt_out);
      end
   endtask

   task automatic t_clear_compl();
      exec(12'o7300, 12'o1234, 1'b1, 12'o0); chk("R2 cla cll", 12'o0000, 1'b0, 1'b0, 1'b0);
      exec(12'o7200, 12'o1234, 1'b1, 12'o0); chk("R2 cla", 12'o0000, 1'b1, 1'b0, 1'b0);
      exec(12'o7040, 12'o0707, 1'b1, 12'o0); chk("R3 cma", 12'o7070, 1'b1, 1'b0, 1'b0);
      exec(12'o7020, 12'o0707, 1'b0, 12'o0); chk("R3 cml", 12'o0707, 1'b1, 1'b0, 1'b0);
      exec(12'o7240, 12'o1234, 1'b0, 12'o0); chk("R3 cla then cma", 12'o7777, 1'b0, 1'b0, 1'b0);
   endtask

   task automatic t_increment();
      exec(12'o7001, 12'o7777, 1'b0, 12'o0); chk("R4 carry into link", 12'o0000, 1'b1, 1'b0, 1'b0);
      exec(12'o7041, 12'o0005, 1'b0, 12'o0); chk("R4 cma iac negate", 12'o7773, 1'b0, 1'b0, 1'b0);
      exec(12'o7005, 12'o3777, 1'b0, 12'o0); chk("R4 iac before ral", 12'o0000, 1'b1, 1'b0, 1'b0);
   endtask

   task automatic t_rotate();
      exec(12'o7010, 12'o0001, 1'b0, 12'o0); chk("R5 rar", 12'o0000, 1'b1, 1'b0, 1'b0);
      exec(12'o7010, 12'o4000, 1'b1, 12'o0); chk("R5 rar link in", 12'o6000, 1'b0, 1'b0, 1'b0);
      exec(12'o7004, 12'o4000, 1'b0, 12'o0); chk("R5 ral", 12'o0000, 1'b1, 1'b0, 1'b0);
      exec(12'o7012, 12'o0001, 1'b0, 12'o0); chk("R5 rtr", 12'o4000, 1'b0, 1'b0, 1'b0);
      exec(12'o7006, 12'o4000, 1'b0, 12'o0); chk("R5 rtl", 12'o0001, 1'b0, 1'b0, 1'b0);
      exec(12'o7326, 12'o5555, 1'b0, 12'o0); chk("R5 cla cll cml rtl", 12'o0002, 1'b0, 1'b0, 1'b0);
   endtask

   task automatic t_swap_odd();
      exec(12'o7002, 12'o0077, 1'b1, 12'o0); chk("R6 half swap", 12'o7700, 1'b1, 1'b0, 1'b0);
      exec(12'o7016, 12'o1234, 1'b1, 12'o0); chk("R6 code 111", 12'o1234, 1'b1, 1'b0, 1'b0);
      exec(12'o7014, 12'o1234, 1'b0, 12'o0); chk("R6 code 110", 12'o1234, 1'b0, 1'b0, 1'b0);
   endtask

   task automatic t_or_skip();
      exec(12'o7500, 12'o4000, 1'b0, 12'o0); chk("R7 sma neg", 12'o4000, 1'b0, 1'b1, 1'b0);
      exec(12'o7500, 12'o3777, 1'b0, 12'o0); chk("R7 sma pos", 12'o3777, 1'b0, 1'b0, 1'b0);
      exec(12'o7440, 12'o0000, 1'b0, 12'o0); chk("R7 sza zero", 12'o0000, 1'b0, 1'b1, 1'b0);
      exec(12'o7420, 12'o0012, 1'b1, 12'o0); chk("R7 snl", 12'o0012, 1'b1, 1'b1, 1'b0);
      exec(12'o7540, 12'o0001, 1'b1, 12'o0); chk("R7 sma sza miss", 12'o0001, 1'b1, 1'b0, 1'b0);
      exec(12'o7540, 12'o0000, 1'b0, 12'o0); chk("R7 sma sza hit", 12'o0000, 1'b0, 1'b1, 1'b0);
   endtask

   task automatic t_and_skip();
      exec(12'o7410, 12'o4321, 1'b1, 12'o0); chk("R8 skp", 12'o4321, 1'b1, 1'b1, 1'b0);
      exec(12'o7510, 12'o3777, 1'b0, 12'o0); chk("R8 spa pos", 12'o3777, 1'b0, 1'b1, 1'b0);
      exec(12'o7510, 12'o4000, 1'b0, 12'o0); chk("R8 spa neg", 12'o4000, 1'b0, 1'b0, 1'b0);
      exec(12'o7470, 12'o0005, 1'b0, 12'o0); chk("R8 sna szl hit", 12'o0005, 1'b0, 1'b1, 1'b0);
      exec(12'o7470, 12'o0005, 1'b1, 12'o0); chk("R8 sna szl miss", 12'o0005, 1'b1, 1'b0, 1'b0);
   endtask

   task automatic t_clear_switch_halt();
      exec(12'o7700, 12'o4321, 1'b0, 12'o0); chk("R9 test before clear", 12'o0000, 1'b0, 1'b1, 1'b0);
      exec(12'o7604, 12'o1234, 1'b1, 12'o0707); chk("R9 cla osr", 12'o0707, 1'b1, 1'b0, 1'b0);
      exec(12'o7404, 12'o0070, 1'b0, 12'o0700); chk("R9 osr", 12'o0770, 1'b0, 1'b0, 1'b0);
      exec(12'o7402, 12'o1111, 1'b1, 12'o0); chk("R10 halt", 12'o1111, 1'b1, 1'b0, 1'b1);
      exec(12'o7012, 12'o0001, 1'b0, 12'o0); chk("R10 no halt in group1", 12'o4000, 1'b0, 1'b0, 1'b0);
   endtask

   task automatic t_noops();
      exec(12'o7000, 12'o5252, 1'b1, 12'o0); chk("R11 g1 nop", 12'o5252, 1'b1, 1'b0, 1'b0);
      exec(12'o7400, 12'o5252, 1'b0, 12'o7777); chk("R11 g2 nop", 12'o5252, 1'b0, 1'b0, 1'b0);
      exec(12'o7703, 12'o1234, 1'b1, 12'o7777); chk("R11 group3 ignored", 12'o1234, 1'b1, 1'b0, 1'b0);
      exec(12'o1234, 12'o6543, 1'b0, 12'o7777); chk("R11 foreign opcode", 12'o6543, 1'b0, 1'b0, 1'b0);
   endtask

   task automatic t_idle();
      exec(12'o7410, 12'o0001, 1'b0, 12'o0);
      @(negedge clk);
      total++;
      if (out_valid !== 1'b0 || skip_out !== 1'b0) begin
         bad++;
         $display("FAIL R1 idle: got v=%b skip=%b, expected v=0 skip=0", out_valid, skip_out);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_clear_compl();
      t_increment();
      t_rotate();
      t_swap_odd();
      t_or_skip();
      t_and_skip();
      t_clear_switch_halt();
      t_noops();
      t_idle();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #50000;
      total++;
      bad++;
      $display("FAIL watchdog: run did not finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule